// File: doc/BRIEF.md
# Double-Buffered Frame Flip Controller

This block owns the two image buffers of a bit-plane scanned LED panel. The scan engine fetches rows from the display buffer, and the application draws into the drawing buffer. When the application asks for a flip, the request waits until the scan comes back to the first row of the first bit-plane. At that point the block exchanges the two base pointers, so that the freshly drawn image is shown from the next row on.

After the exchange, the new drawing buffer still holds an old image. A copy engine therefore moves every word of the new display buffer into the new drawing buffer. It reads one word, then writes it, over a plain word-wide memory port with one request and one acknowledge per access. The flip counts as busy until the last word has been written. Drawing can then continue from the image that is on screen.

The scan position is an input. The scan has PLANES bit-planes of HEIGHT/2 rows each, and after the last plane it wraps to plane 0. For every row start, the block returns the fetch address of that row, worked out from the display pointer at that moment.

Top module: `fbuf_flip`

## Requirements
- R1: After reset the drawing pointer is FRONT_BASE (0x0100), the display pointer is BACK_BASE (0x0200), flip_busy and flip_done are low and mem_req is low.
- R2: The pointers change only on the clock edge at which row_start is high with scan_plane = 0 and scan_row = 0.
- R3: On the first such edge after a flip request, the drawing and display pointers exchange values.
- R4: The copy moves WIDTH×HEIGHT words. Each word is first read (mem_we = 0) from display pointer + i and then written (mem_we = 1) to drawing pointer + i, for i rising from 0. Only one access is outstanding at a time, and mem_req, mem_we and mem_addr hold steady until mem_ack.
- R5: flip_busy rises on the edge after a flip_req pulse taken while idle. flip_done pulses high for one cycle on the edge after the last write is acknowledged. flip_busy falls on the following edge unless another flip is queued.
- R6: A flip_req that arrives while a copy is running is kept. After the copy completes, flip_busy stays high and that flip waits for the next frame start.
- R7: A flip_req that arrives while a flip is already waiting for the frame start merges with it, and only one exchange takes place.
- R8: One edge after row_start, row_addr equals the display pointer plus scan_row×WIDTH×2. If an exchange happens on the same edge, the exchanged display pointer is used.
- R9: Each write carries the data returned by the read of the same word, so that after flip_done the whole drawing buffer equals the display buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| flip_req | input | 1 | One-cycle pulse asking for a buffer flip |
| flip_busy | output | 1 | A flip is waiting or its copy is running |
| flip_done | output | 1 | One-cycle pulse when the copy completes |
| row_start | input | 1 | Scan engine begins the row given by scan_plane/scan_row |
| scan_plane | input | 4 | Current bit-plane index, 0 to PLANES-1 |
| scan_row | input | 1 | Current row pair index, 0 to HEIGHT/2-1 |
| front_base | output | 16 | Drawing buffer base address |
| back_base | output | 16 | Display buffer base address |
| row_addr | output | 16 | Fetch address of the row last started |
| mem_req | output | 1 | Copy access request |
| mem_we | output | 1 | Access is a write when high, a read when low |
| mem_addr | output | 16 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume the following of the inputs. On every row_start the plane index is below PLANES and the row index is below HEIGHT/2. mem_ack is raised only while mem_req is high, and for at most one cycle per access. flip_req is a single-cycle pulse. The stimulus walks the scan position in order and wraps the plane after the last one. It inserts random gaps, including zero-cycle gaps, between row starts. Acknowledges come only against a live request, after 0 to 2 cycles of wait. Flip pulses are issued at random, so they fall into the idle, waiting and copying phases alike.

// File: rtl/fbuf_flip_pkg.sv
package fbuf_flip_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_COPY = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    CP_IDLE  = 2'd0,
    CP_READ  = 2'd1,
    CP_WRITE = 2'd2
  } copy_state_e;
endpackage

// File: rtl/fbuf_flip_seq.sv
module fbuf_flip_seq
  import fbuf_flip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flip_req,
  input  logic at_boundary,
  input  logic copy_done,
  output logic swap_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;
  logic       queued_q, queued_d;

  always_comb begin
    state_d  = state_q;
    queued_d = queued_q;
    swap_o   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (flip_req) state_d = SEQ_WAIT;
      SEQ_WAIT: if (at_boundary) begin
        swap_o  = 1'b1;
        state_d = SEQ_COPY;
      end
      SEQ_COPY: begin
        if (copy_done) begin
          state_d  = (queued_q || flip_req) ? SEQ_WAIT : SEQ_IDLE;
          queued_d = 1'b0;
        end else if (flip_req) begin
          queued_d = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      queued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      queued_q <= queued_d;
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);

  // R6
  done_in_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> state_q == SEQ_COPY);

  // R7
  wait_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT && !at_boundary) |=> state_q == SEQ_WAIT && !queued_q);
endmodule

// File: rtl/fbuf_ptr_swap.sv
module fbuf_ptr_swap #(
  parameter int          ADDR_W     = 16,
  parameter int          ROW_W      = 1,
  parameter int          ROW_STRIDE = 16,
  parameter logic [15:0] FRONT_BASE = 16'h0100,
  parameter logic [15:0] BACK_BASE  = 16'h0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap,
  input  logic              row_start,
  input  logic [ROW_W-1:0]  row_idx,
  output logic [ADDR_W-1:0] front_o,
  output logic [ADDR_W-1:0] back_o,
  output logic [ADDR_W-1:0] row_addr_o
);
  logic [ADDR_W-1:0] front_q, back_q, row_addr_q;
  logic [ADDR_W-1:0] front_d, back_d, row_addr_d, disp_base;

  always_comb begin
    front_d    = front_q;
    back_d     = back_q;
    row_addr_d = row_addr_q;
    disp_base  = swap ? front_q : back_q;
    if (swap) begin
      front_d = back_q;
      back_d  = front_q;
    end
    if (row_start)
      row_addr_d = disp_base + ADDR_W'(row_idx) * ADDR_W'(ROW_STRIDE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front_q    <= ADDR_W'(FRONT_BASE);
      back_q     <= ADDR_W'(BACK_BASE);
      row_addr_q <= ADDR_W'(BACK_BASE);
    end else begin
      front_q    <= front_d;
      back_q     <= back_d;
      row_addr_q <= row_addr_d;
    end
  end

  assign front_o    = front_q;
  assign back_o     = back_q;
  assign row_addr_o = row_addr_q;

  // R3
  ptr_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    front_q != back_q);
endmodule

// File: rtl/fbuf_copier.sv
module fbuf_copier
  import fbuf_flip_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_o
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  copy_state_e       state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    done_d  = 1'b0;
    unique case (state_q)
      CP_IDLE: if (start) begin
        src_d   = src_base;
        dst_d   = dst_base;
        cnt_d   = '0;
        state_d = CP_READ;
      end
      CP_READ: if (mem_ack) begin
        data_d  = mem_rdata;
        state_d = CP_WRITE;
      end
      CP_WRITE: if (mem_ack) begin
        if (cnt_q == CNT_W'(WORDS - 1)) begin
          state_d = CP_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = CP_READ;
        end
      end
      default: state_d = CP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CP_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      done_q  <= done_d;
    end
  end

  assign mem_req   = (state_q != CP_IDLE);
  assign mem_we    = (state_q == CP_WRITE);
  assign mem_addr  = (state_q == CP_WRITE ? dst_q : src_q) + ADDR_W'(cnt_q);
  assign mem_wdata = data_q;
  assign done_o    = done_q;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !mem_req);

  // R9
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));
endmodule

// File: rtl/fbuf_flip.sv
module fbuf_flip #(
  parameter int          WIDTH      = 8,
  parameter int          HEIGHT     = 4,
  parameter int          PLANES     = 10,
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter logic [15:0] FRONT_BASE = 16'h0100,
  parameter logic [15:0] BACK_BASE  = 16'h0200,
  localparam int         ROWS       = HEIGHT / 2,
  localparam int         ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int         PLANE_W    = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flip_req,
  output logic               flip_busy,
  output logic               flip_done,
  input  logic               row_start,
  input  logic [PLANE_W-1:0] scan_plane,
  input  logic [ROW_W-1:0]   scan_row,
  output logic [ADDR_W-1:0]  front_base,
  output logic [ADDR_W-1:0]  back_base,
  output logic [ADDR_W-1:0]  row_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata
);
  localparam int WORDS      = WIDTH * HEIGHT;
  localparam int ROW_STRIDE = WIDTH * 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       at_boundary, swap, copy_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign at_boundary = row_start && (scan_plane == '0) && (scan_row == '0);

  fbuf_flip_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .flip_req    (flip_req),
    .at_boundary (at_boundary),
    .copy_done   (copy_done),
    .swap_o      (swap),
    .busy_o      (flip_busy)
  );

  fbuf_ptr_swap #(
    .ADDR_W     (ADDR_W),
    .ROW_W      (ROW_W),
    .ROW_STRIDE (ROW_STRIDE),
    .FRONT_BASE (FRONT_BASE),
    .BACK_BASE  (BACK_BASE)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .swap       (swap),
    .row_start  (row_start),
    .row_idx    (scan_row),
    .front_o    (front_base),
    .back_o     (back_base),
    .row_addr_o (row_addr)
  );

  // The new display buffer is the old drawing buffer and vice versa.
  fbuf_copier #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
  ) u_copy (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (swap),
    .src_base  (front_base),
    .dst_base  (back_base),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done_o    (copy_done)
  );

  assign flip_done = copy_done;

  // R2
  ptr_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(front_base) |-> $past(row_start && scan_plane == '0 && scan_row == '0));

  // R5
  done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    flip_done |-> flip_busy);

  // R4
  copy_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req |-> flip_busy);

  // R8
  scan_pos_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    row_start |-> (int'(scan_plane) < PLANES) && (int'(scan_row) < ROWS));
endmodule

// File: tb/tb_fbuf_flip.sv
`timescale 1ns/1ps
module tb_fbuf_flip;
  localparam int W = 8, H = 4, PL = 10, ROWS = H / 2, N = W * H;
  localparam int FB = 'h100, BB = 'h200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flip_req = 0, row_start = 0, mem_ack = 0;
  logic [3:0] scan_plane = 0;
  logic [0:0] scan_row = 0;
  logic [31:0] mem_rdata = 0;
  logic flip_busy, flip_done, mem_req, mem_we;
  logic [15:0] front_base, back_base, row_addr, mem_addr;
  logic [31:0] mem_wdata;

  always #2 clk = ~clk;

  fbuf_flip dut (.clk, .rst_n, .flip_req, .flip_busy, .flip_done, .row_start,
    .scan_plane, .scan_row, .front_base, .back_base, .row_addr, .mem_req,
    .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata);

  int vectors = 0, fails = 0;
  bit finished = 0;
  logic [31:0] mem [0:1023];

  // Reference model state
  int m_seq, m_queued, m_front, m_back, m_row_addr;
  int c_st, c_src, c_dst, c_cnt, c_done;
  logic [31:0] c_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_seq = 0; m_queued = 0; m_front = FB; m_back = BB; m_row_addr = BB;
      c_st = 0; c_src = 0; c_dst = 0; c_cnt = 0; c_done = 0; c_data = 0;
    end else begin
      automatic bit bnd = row_start && scan_plane == 0 && scan_row == 0;
      automatic bit sw = (m_seq == 1) && bnd;
      automatic int of = m_front, ob = m_back;
      automatic int nd = 0;
      if (row_start) m_row_addr = ((sw ? of : ob) + int'(scan_row) * W * 2) & 'hFFFF;
      if (sw) begin m_front = ob; m_back = of; end
      case (c_st)
        0: if (sw) begin c_src = of; c_dst = ob; c_cnt = 0; c_st = 1; end
        1: if (mem_ack) begin c_data = mem_rdata; c_st = 2; end
        default: if (mem_ack) begin
          if (c_cnt == N - 1) begin c_st = 0; nd = 1; end
          else begin c_cnt++; c_st = 1; end
        end
      endcase
      case (m_seq)
        0: if (flip_req) m_seq = 1;
        1: if (sw) m_seq = 2;
        default:
          if (c_done) begin m_seq = (m_queued || flip_req) ? 1 : 0; m_queued = 0; end
          else if (flip_req) m_queued = 1;
      endcase
      c_done = nd;
    end
  end

  // Memory side: writes land at the edge they are acknowledged
  always @(posedge clk)
    if (rst_n && mem_req && mem_we && mem_ack) mem[mem_addr[9:0]] <= mem_wdata;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  logic [15:0] last_front = 16'(FB);
  logic        last_bnd = 0;

  task automatic compare();
    check("R5", "flip_busy", flip_busy, m_seq != 0);
    check("R5 R6 R7", "flip_done", flip_done, c_done);
    check("R3", "front_base", front_base, m_front);
    check("R3", "back_base", back_base, m_back);
    check("R8", "row_addr", row_addr, m_row_addr);
    check("R4", "mem_req", mem_req, c_st != 0);
    if (c_st != 0) begin
      check("R4", "mem_we", mem_we, c_st == 2);
      check("R4", "mem_addr", mem_addr, ((c_st == 2 ? c_dst : c_src) + c_cnt) & 'hFFFF);
    end
    if (c_st == 2) check("R9", "mem_wdata", mem_wdata, c_data);
    // R2: a pointer change must follow a frame-start edge
    if (front_base != last_front) check("R2", "swap at frame start", last_bnd, 1);
    last_front = front_base;
    // R9: after completion the drawing buffer mirrors the display buffer
    if (flip_done) begin
      automatic int bad = 0;
      for (int i = 0; i < N; i++)
        if (mem[(front_base + i) & 1023] !== mem[(back_base + i) & 1023]) bad++;
      check("R9", "buffer mismatches after copy", bad, 0);
    end
  endtask

  int gap = 0, ack_wait = 0;
  bit rs_prev = 0;

  task automatic drive();
    // scan position: advance after each issued row
    if (rs_prev) begin
      if (scan_row == 1'(ROWS - 1)) begin
        scan_row = 0;
        scan_plane = (scan_plane == 4'(PL - 1)) ? 4'd0 : scan_plane + 1'b1;
      end else scan_row = scan_row + 1'b1;
    end
    if (gap == 0) begin row_start = 1; gap = $urandom_range(0, 3); end
    else begin row_start = 0; gap--; end
    rs_prev = row_start;
    last_bnd = row_start && scan_plane == 0 && scan_row == 0;
    flip_req = ($urandom_range(0, 49) == 0);
    // memory acknowledge after 0..2 wait cycles
    mem_ack = 0;
    if (mem_req) begin
      if (ack_wait == 0) begin
        mem_ack = 1;
        mem_rdata = mem[mem_addr[9:0]];
        ack_wait = $urandom_range(0, 2);
      end else ack_wait--;
    end
    // application draws while no flip is outstanding
    if (m_seq == 0 && $urandom_range(0, 3) == 0)
      mem[(m_front + $urandom_range(0, N - 1)) & 1023] = $urandom;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "front_base", front_base, FB);
    check("R1", "back_base", back_base, BB);
    check("R1", "flip_busy", flip_busy, 0);
    check("R1", "flip_done", flip_done, 0);
    check("R1", "mem_req", mem_req, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      compare();
      drive();
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule